// File: doc/BRIEF.md
# DSP Host Port with Level Host Request

This block sits between a byte-wide host processor bus and the peripheral bus of a signal processor. Each side sees its own small set of registers. A word the signal processor writes to its transmit register moves into a 24-bit host receive register, and the host collects it as three separate bytes. Bytes the host writes travel the other way and come together in a word that the signal processor reads.

The host sees two flags: receive-full and transmit-empty. Two enable bits in the host control register pick which flags may raise the host request output. That output is a live combination of the stored flags and enables. It is not a latched pending event, so it drops as soon as its cause is gone, for example after the host reads the receive low byte. The same level appears in bit 7 of the host status register, so polling software and an interrupt controller always see the same value.

Top module: `hostlink_port`

## Requirements
- R1: `h_req` equals (control bit 0 AND receive-full) OR (control bit 1 AND transmit-empty) in every cycle. It stays high while either enabled flag is set and is low once both enabled flags are clear.
- R2: A host read at offset 2 returns the status byte: bit 0 receive-full, bit 1 transmit-empty, bit 7 the current `h_req` level, bits 6..2 zero. Host writes to offset 2 change nothing.
- R3: Offset 0 is the host control register. Bits 1..0 are writable and read back, and bits 7..2 read as zero. Writing 2 enables only the transmit-empty request.
- R4: While both control enable bits are zero, `h_req` stays low whatever the flags are.
- R5: A host read at offset 7 returns the receive word's low byte and clears receive-full at that clock edge. If receive-full was the only enabled cause, `h_req` is low from the next cycle.
- R6: Host reads at offsets 5 and 6 return the receive word's high byte (bits 23..16) and middle byte (bits 15..8) and change no flag.
- R7: On the signal-processor side, `d_addr`=0 reads status: bit 1 is transmit-empty and bit 0 is receive-full. A write with `d_addr`=1 stores the word and clears bit 1. At the next edge where host receive-full is clear, the word moves into the host receive register, sets receive-full and sets bit 1 again. While the host receive register is full, the word waits and the held receive word does not change.
- R8: Host writes to offsets 5, 6 and 7 set the high, middle and low bytes of the outgoing word. A write to offset 7 clears host transmit-empty and sets signal-processor receive-full. A read with `d_addr`=1 returns the word and sets transmit-empty again.
- R9: After synchronous active-high reset, the control register and all data registers are zero, receive-full is 0, and both transmit-empty flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 3 | Host byte offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects at the edge) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from `h_addr` |
| h_req | output | 1 | Level host request |
| d_addr | input | 1 | Signal-processor select: 0 status, 1 data |
| d_wr | input | 1 | Signal-processor write strobe |
| d_rd | input | 1 | Signal-processor read strobe |
| d_wdata | input | 24 | Signal-processor write data |
| d_rdata | output | 24 | Signal-processor read data, combinational |

## Verification
A receive-full flag that stays set after the low-byte read shows up within one cycle as `h_req` still high and status bit 0 still set. That is the kind of stuck request that fires a spurious host interrupt. A wrong transmit-empty flag shows as a request when only the transmit enable is set, visible right after the host commits its low byte. Transfer-ordering errors show as a wrong signal-processor status bit 1 or a receive byte that changed while full, one cycle after the signal processor writes.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int unsigned OFF_CTRL   = 0;
  localparam int unsigned OFF_STAT   = 2;
  localparam int unsigned OFF_RX_LOW = 7;
  localparam int unsigned STAT_RXF   = 0;
  localparam int unsigned STAT_TXE   = 1;
  localparam int unsigned STAT_REQ   = 7;

  // request level: any enabled flag that is set
  function automatic logic req_level(input logic [1:0] en, input logic [1:0] flags);
    return |(en & flags);
  endfunction
endpackage

// File: rtl/hostlink_d2h.sv
module hostlink_d2h #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dsp_wr_ev,
  input  logic [DATA_W-1:0] dsp_wdata,
  input  logic              low_read_ev,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_full,
  output logic              dsp_tx_empty
);
  logic [DATA_W-1:0] htx_q;
  logic              xfer_ev;

  assign xfer_ev = !dsp_tx_empty && !rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      htx_q        <= '0;
      dsp_tx_empty <= 1'b1;
    end else if (dsp_wr_ev) begin
      htx_q        <= dsp_wdata;
      dsp_tx_empty <= 1'b0;
    end else if (xfer_ev) begin
      dsp_tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
      rx_full <= 1'b0;
    end else if (xfer_ev) begin
      rx_word <= htx_q;
      rx_full <= 1'b1;
    end else if (low_read_ev) begin
      rx_full <= 1'b0;
    end
  end

  // R5
  low_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (low_read_ev && rx_full) |=> !rx_full);
  // R7
  xfer_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_ev && !dsp_wr_ev) |=> (rx_full && dsp_tx_empty));
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !low_read_ev) |=> $stable(rx_word));
endmodule

// File: rtl/hostlink_h2d.sv
module hostlink_h2d #(
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBYTES-1:0] byte_wr_ev,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              dsp_rd_ev,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_empty
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                tx_word[i*BYTE_W +: BYTE_W] <= '0;
      else if (byte_wr_ev[i]) tx_word[i*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                tx_empty <= 1'b1;
    else if (byte_wr_ev[0]) tx_empty <= 1'b0;
    else if (dsp_rd_ev)     tx_empty <= 1'b1;
  end

  // R8
  commit_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    byte_wr_ev[0] |=> !tx_empty);
  // R8
  dsp_read_sets_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (dsp_rd_ev && !byte_wr_ev[0]) |=> tx_empty);
endmodule

// File: rtl/hostlink_req.sv
module hostlink_req
  import hostlink_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ctrl_en,
  input  logic       rx_full,
  input  logic       tx_empty,
  output logic       req
);
  assign req = req_level(ctrl_en, {tx_empty, rx_full});

  // R4
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en == 2'b00) |-> !req);
  // R1
  no_req_no_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_full && !tx_empty) |-> !req);
endmodule

// File: rtl/hostlink_port.sv
module hostlink_port
  import hostlink_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int BYTE_W  = 8,
  parameter int HADDR_W = 3,
  localparam int NBYTES = DATA_W / BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [BYTE_W-1:0]  h_wdata,
  output logic [BYTE_W-1:0]  h_rdata,
  output logic               h_req,
  input  logic               d_addr,
  input  logic               d_wr,
  input  logic               d_rd,
  input  logic [DATA_W-1:0]  d_wdata,
  output logic [DATA_W-1:0]  d_rdata
);
  logic [1:0]        ctrl_q;
  logic [NBYTES-1:0] byte_wr_ev;
  logic              low_read_ev, dsp_wr_ev, dsp_rd_ev, ctrl_wr_ev;
  logic [DATA_W-1:0] rx_word, tx_word;
  logic              rx_full, tx_empty, dsp_tx_empty;
  logic [BYTE_W-1:0] stat_byte;

  assign ctrl_wr_ev  = h_wr && (h_addr == HADDR_W'(OFF_CTRL));
  assign low_read_ev = h_rd && (h_addr == HADDR_W'(OFF_RX_LOW));
  assign dsp_wr_ev   = d_wr && d_addr;
  assign dsp_rd_ev   = d_rd && d_addr;

  for (genvar i = 0; i < NBYTES; i++) begin : g_dec
    assign byte_wr_ev[i] = h_wr && (h_addr == HADDR_W'(OFF_RX_LOW - i));
  end

  always_ff @(posedge clk) begin
    if (rst)             ctrl_q <= 2'b00;
    else if (ctrl_wr_ev) ctrl_q <= h_wdata[1:0];
  end

  hostlink_d2h #(.DATA_W(DATA_W)) u_d2h (
    .clk(clk), .rst(rst), .dsp_wr_ev(dsp_wr_ev), .dsp_wdata(d_wdata),
    .low_read_ev(low_read_ev), .rx_word(rx_word), .rx_full(rx_full),
    .dsp_tx_empty(dsp_tx_empty)
  );

  hostlink_h2d #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_h2d (
    .clk(clk), .rst(rst), .byte_wr_ev(byte_wr_ev), .wdata(h_wdata),
    .dsp_rd_ev(dsp_rd_ev), .tx_word(tx_word), .tx_empty(tx_empty)
  );

  hostlink_req u_req (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_q), .rx_full(rx_full),
    .tx_empty(tx_empty), .req(h_req)
  );

  always_comb begin
    stat_byte           = '0;
    stat_byte[STAT_RXF] = rx_full;
    stat_byte[STAT_TXE] = tx_empty;
    stat_byte[STAT_REQ] = h_req;
  end

  always_comb begin
    h_rdata = '0;
    if (h_addr == HADDR_W'(OFF_CTRL)) h_rdata = {{(BYTE_W-2){1'b0}}, ctrl_q};
    if (h_addr == HADDR_W'(OFF_STAT)) h_rdata = stat_byte;
    for (int i = 0; i < NBYTES; i++) begin
      if (h_addr == HADDR_W'(OFF_RX_LOW - i)) h_rdata = rx_word[i*BYTE_W +: BYTE_W];
    end
  end

  assign d_rdata = d_addr ? tx_word : {{(DATA_W-2){1'b0}}, dsp_tx_empty, !tx_empty};

  // R2
  stat_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (h_addr == HADDR_W'(OFF_STAT)) |-> (h_rdata[STAT_REQ] == h_req));
  // R3
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_ev |=> (h_rdata[1:0] == $past(h_wdata[1:0]) || h_addr != HADDR_W'(OFF_CTRL)));
endmodule

// File: tb/hostlink_port_bench.sv
module hostlink_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic        h_req;
  logic        d_addr = 1'b0, d_wr = 1'b0, d_rd = 1'b0;
  logic [23:0] d_wdata = '0;
  logic [23:0] d_rdata;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  hostlink_port u_hostlink_port (.*);

  // vector: {ctrl[1:0], dsp pushes word, host commits low byte, expected request}
  localparam logic [4:0] VEC [10] = '{
    5'b00_0_0_0, 5'b00_1_0_0, 5'b01_0_0_0, 5'b01_1_0_1, 5'b10_0_0_1,
    5'b10_0_1_0, 5'b10_1_1_0, 5'b11_1_1_1, 5'b11_0_1_0, 5'b01_1_1_1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst = 1'b1; tick; tick; rst = 1'b0;
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    h_addr = a; h_wdata = d; h_wr = 1'b1; tick; h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    h_addr = a; h_rd = 1'b1; #1 d = h_rdata; tick; h_rd = 1'b0;
  endtask

  task automatic dwr(input logic [23:0] w);
    d_addr = 1'b1; d_wdata = w; d_wr = 1'b1; tick; d_wr = 1'b0;
  endtask

  task automatic drd(output logic [23:0] w);
    d_addr = 1'b1; d_rd = 1'b1; #1 w = d_rdata; tick; d_rd = 1'b0;
  endtask

  task automatic dstat(output logic [1:0] s);
    d_addr = 1'b0; #1 s = d_rdata[1:0];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [1:0]  s;
    logic [23:0] w;

    // R9 reset state
    do_reset;
    chk("R9 req after reset", h_req, 0);
    hrd(3'd2, b); chk("R9 status after reset", b, 8'h02);
    hrd(3'd0, b); chk("R9 control after reset", b, 8'h00);
    hrd(3'd7, b); chk("R9 rx low after reset", b, 8'h00);
    dstat(s); chk("R9 dsp status after reset", s, 2'b10);

    // R1/R2/R4 table walk
    for (int k = 0; k < 10; k++) begin
      do_reset;
      hwr(3'd0, {6'b0, VEC[k][4:3]});
      if (VEC[k][2]) begin dwr(24'h123456); tick; end
      if (VEC[k][1]) hwr(3'd7, 8'h55);
      chk($sformatf("R1 R4 request vec %0d", k), h_req, VEC[k][0]);
      hrd(3'd2, b);
      chk($sformatf("R2 status vec %0d", k), b, {VEC[k][0], 5'b0, ~VEC[k][1], VEC[k][2]});
    end

    // R3 control register
    do_reset;
    hwr(3'd0, 8'hFF); hrd(3'd0, b); chk("R3 control readback", b, 8'h03);
    hwr(3'd0, 8'h02); chk("R3 transmit-only enable", h_req, 1);
    dwr(24'hABCDEF); tick;
    hwr(3'd7, 8'h00); chk("R3 receive ignored when disabled", h_req, 0);

    // R2 status writes ignored
    do_reset;
    hwr(3'd2, 8'hFF); hrd(3'd2, b); chk("R2 status write ignored", b, 8'h02);

    // R5/R6/R7 receive path
    do_reset;
    hwr(3'd0, 8'h01);
    dwr(24'hA5B6C7);
    dstat(s); chk("R7 dsp tx flag cleared by write", s[1], 0);
    chk("R7 no request before transfer", h_req, 0);
    tick;
    dstat(s); chk("R7 dsp tx flag set after transfer", s[1], 1);
    chk("R7 request after transfer", h_req, 1);
    dwr(24'h010203); tick; tick;
    dstat(s); chk("R7 second word waits while full", s[1], 0);
    hrd(3'd5, b); chk("R6 high byte", b, 8'hA5);
    hrd(3'd6, b); chk("R6 middle byte", b, 8'hB6);
    chk("R6 request unchanged by high reads", h_req, 1);
    hrd(3'd7, b); chk("R5 low byte", b, 8'hC7);
    chk("R5 request falls after low read", h_req, 0);
    tick;
    chk("R7 pending word transferred", h_req, 1);
    hrd(3'd5, b); chk("R7 new high byte", b, 8'h01);
    dstat(s); chk("R7 dsp tx flag after late transfer", s[1], 1);

    // R8 transmit path
    do_reset;
    hwr(3'd5, 8'h11); hwr(3'd6, 8'h22);
    hrd(3'd2, b); chk("R8 empty kept before low write", b[1], 1);
    hwr(3'd7, 8'h33);
    hrd(3'd2, b); chk("R8 empty cleared by low write", b[1], 0);
    dstat(s); chk("R8 dsp receive full", s[0], 1);
    drd(w); chk("R8 dsp reads word", w, 24'h112233);
    hrd(3'd2, b); chk("R8 empty set by dsp read", b[1], 1);
    dstat(s); chk("R8 dsp receive cleared", s[0], 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule